// File: doc/BRIEF.md
# Serial Autobaud Sync Detector

This block sits on the idle-high receive line of an 8N1 serial port and learns the bit period from a known sync byte, the greater-than sign (0x3E). On every falling edge it looks at two timings. The first is the time since the previous falling edge. The second is the width of the high pulse that just ended. For 0x3E these two timings are seven and five bit times. When their ratio fits, the bit period is taken as one seventh of the fall-to-fall time.

Acquisition takes two steps. The first sync byte that fits loads the period and raises `locked`. A second fitting byte, with no long idle gap before it, raises `rx_en`. This way the companion receiver is switched on before the start bit of the following character. Once enabled, the block decodes frames on its own at the learned rate. Each correctly framed 0x3E is timed from rising edge to rising edge, which lets the period follow slow clock drift. If no lock is reached within a programmable number of cycles after reset (sixty seconds by default), the block requests power-down. That request holds until the next reset.

Top module: `autobaud_detect`

## Requirements
- R1: After reset, `bit_period` is 0 and `locked`, `rx_en` and `power_down` are all low.
- R2: Each falling edge of `rx` is judged as a candidate, two clocks after the edge reaches the synchronizer. Here ff is the number of clocks since the previous falling edge and hi is the number of clocks the line stayed high before this edge. The candidate fits when ff <= LIMIT, hi <= LIMIT and |5*ff - 7*hi| <= floor(ff/7).
- R3: A candidate with ff or hi above LIMIT never fits, even when its ratio is exact (ff = LIMIT fits, ff = LIMIT+1 does not).
- R4: A fitting candidate while searching sets `bit_period` = floor(ff/7) and raises `locked`, while `rx_en` stays low.
- R5: While locked but not enabled, the next fitting candidate raises `rx_en` and reloads `bit_period` = floor(ff/7). A back-to-back pair of 0x3E frames therefore enables the receiver.
- R6: While locked but not enabled, a falling edge with ff above LIMIT returns the block to searching with `locked` low. In this state, a non-fitting edge within LIMIT is ignored.
- R7: With `rx_en` high, frames are sampled at mid-bit using `bit_period`, 8 data bits LSB first and a stop bit that must be 1. A frame that decodes to 0x3E sets `bit_period` to floor(r/7). Here r is the number of clocks between the last two rising edges, which are the rise into data bit 1 and the rise into the stop bit.
- R8: With `rx_en` high, a frame decoding to any other byte, and any fitting fall-to-fall candidate, leave `bit_period` unchanged.
- R9: If the block is never locked, `power_down` rises on the clock edge numbered TIMEOUT_CYCLES, counting the first edge after reset release as edge 1. The count restarts from zero whenever `locked` rises.
- R10: `power_down` stays high until reset, and no candidate is accepted while it is high.
- R11: When the first fitting candidate falls on the same edge as the timeout expiry, the lock wins: `locked` rises and `power_down` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx | input | 1 | Serial receive line, idle high, asynchronous |
| bit_period | output | CW = clog2(LIMIT+2) | Learned bit period in clocks |
| locked | output | 1 | A bit period has been learned |
| rx_en | output | 1 | Receiver enable after the doubled sync byte |
| power_down | output | 1 | Sticky request after acquisition timeout |

## Verification
The timeout expiry and the first lock can land on the same clock edge. Which one wins decides whether the part sleeps. The bench first measures the edge on which a doubled sync byte locks after a short idle lead-in. It then repeats the same waveform on an instance with a short timeout, with the lead-in stretched so that the lock lands exactly on the expiry edge. A further run moves the lock one edge later. On the tie, `locked` must be high and `power_down` low. One edge later, `power_down` must be high and the sync bytes ignored.

// File: rtl/ab_pkg.sv
// Shared types for the autobaud sync detector.
package ab_pkg;
    // Acquisition phase: hunting, period loaded, receiver enabled and tracking
    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_ARMED  = 2'd1,
        ST_TRACK  = 2'd2
    } ab_state_e;

    localparam logic [7:0] SYNC_BYTE = 8'h3E;
    localparam int         FF_BITS   = 7;   // fall-to-fall span of the sync byte
    localparam int         HI_BITS   = 5;   // high pulse inside that span
endpackage

// File: rtl/ab_edge_timer.sv
// Synchronizes the receive line and times its edges.
// Assumes rx is asynchronous and idle high; counters saturate at SAT so a
// long idle reads as out of range. ff_cnt: clocks since last fall,
// hi_cnt: clocks since last rise, rr_len: last rise-to-rise interval.
module ab_edge_timer #(
    parameter int CW  = 12,
    parameter int SAT = 4001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    output logic          rx_s,
    output logic          fall,
    output logic          rise,
    output logic [CW-1:0] ff_cnt,
    output logic [CW-1:0] hi_cnt,
    output logic [CW-1:0] rr_len
);
    localparam logic [CW-1:0] SAT_V = CW'(SAT);
    localparam logic [CW-1:0] ONE_V = CW'(1);

    logic s1, s2, s3;
    logic [CW-1:0] ff_q, hi_q, rr_q;

    function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] v);
        return (v >= SAT_V) ? SAT_V : v + ONE_V;
    endfunction

    // Two-flop synchronizer plus one delay stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= rx;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign rx_s = s2;
    assign fall = s3 & ~s2;
    assign rise = ~s3 & s2;

    // Interval counters restarted by their edge, rise-to-rise captured on rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ff_q <= SAT_V;
            hi_q <= SAT_V;
            rr_q <= SAT_V;
        end else begin
            ff_q <= fall ? ONE_V : sat_inc(ff_q);
            hi_q <= rise ? ONE_V : sat_inc(hi_q);
            if (rise) rr_q <= hi_q;
        end
    end

    assign ff_cnt = ff_q;
    assign hi_cnt = hi_q;
    assign rr_len = rr_q;
endmodule

// File: rtl/ab_ratio_chk.sv
// Judges one candidate edge pair against the 7:5 shape of the sync byte.
// Pure combinational; tolerance is floor(ff/7), integer arithmetic only.
module ab_ratio_chk #(
    parameter int CW    = 12,
    parameter int LIMIT = 4000
) (
    input  logic [CW-1:0] ff,
    input  logic [CW-1:0] hi,
    output logic          in_range,
    output logic          fits
);
    import ab_pkg::*;
    localparam int PW = CW + 4;

    logic [PW-1:0] a, b, diff, tol;

    // Scale both sides, take the absolute gap, compare with the tolerance
    always_comb begin
        in_range = (ff <= CW'(LIMIT)) && (hi <= CW'(LIMIT));
        a        = PW'(ff) * PW'(HI_BITS);
        b        = PW'(hi) * PW'(FF_BITS);
        diff     = (a > b) ? (a - b) : (b - a);
        tol      = PW'(ff / CW'(FF_BITS));
        fits     = in_range && (diff <= tol);
    end
endmodule

// File: rtl/ab_frame_rx.sv
// Minimal 8N1 frame sampler used only to spot sync bytes while tracking.
// Assumes period >= 1 whenever en is high; samples at 1.5, 2.5 ... 9.5 bit
// times after the detected start edge, LSB first.
module ab_frame_rx #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rx_s,
    input  logic          fall,
    input  logic [CW-1:0] period,
    output logic          done,
    output logic          stop_ok,
    output logic [7:0]    data
);
    localparam int MW = CW + 3;

    logic          busy;
    logic [MW-1:0] cnt, mid;
    logic [3:0]    idx;
    logic [7:0]    sh;

    // Frame sequencer: start on a fall, shift data, report at the stop bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            mid     <= '0;
            idx     <= '0;
            sh      <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                busy <= 1'b0;
            end else if (!busy) begin
                if (fall) begin
                    busy <= 1'b1;
                    cnt  <= MW'(1);
                    mid  <= MW'(period) + MW'(period >> 1);
                    idx  <= '0;
                end
            end else begin
                cnt <= cnt + MW'(1);
                if (cnt == mid) begin
                    if (idx == 4'd8) begin
                        done    <= 1'b1;
                        stop_ok <= rx_s;
                        busy    <= 1'b0;
                    end else begin
                        sh  <= {rx_s, sh[7:1]};
                        idx <= idx + 4'd1;
                        mid <= mid + MW'(period);
                    end
                end
            end
        end
    end

    assign data = sh;

    // R7
    fr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

// File: rtl/autobaud_detect.sv
// Autobaud sync detector: learns the bit period from 0x3E, enables the
// receiver after a doubled sync byte, then tracks drift on later 0x3E
// frames. Requests power-down if no lock within TIMEOUT_CYCLES.
// Assumes an idle-high 8N1 line; rx may be asynchronous.
module autobaud_detect #(
    parameter int          LIMIT          = 4000,
    parameter logic [39:0] TIMEOUT_CYCLES = 40'd15_000_000_000,
    localparam int         CW             = $clog2(LIMIT + 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx,
    output logic [CW-1:0] bit_period,
    output logic          locked,
    output logic          rx_en,
    output logic          power_down
);
    import ab_pkg::*;
    localparam int TW = $clog2(TIMEOUT_CYCLES + 40'd1);

    ab_state_e     state;
    logic [CW-1:0] period_q;
    logic [TW-1:0] tmo_q;
    logic          pd_q;

    logic          rx_s, fall, rise;
    logic [CW-1:0] ff_cnt, hi_cnt, rr_len;
    logic          in_range, fits;
    logic          f_done, f_stop;
    logic [7:0]    f_data;
    logic          lock_now, track_upd;

    ab_edge_timer #(.CW(CW), .SAT(LIMIT + 1)) u_edges (
        .clk(clk), .rst_n(rst_n), .rx(rx), .rx_s(rx_s), .fall(fall),
        .rise(rise), .ff_cnt(ff_cnt), .hi_cnt(hi_cnt), .rr_len(rr_len)
    );

    ab_ratio_chk #(.CW(CW), .LIMIT(LIMIT)) u_ratio (
        .ff(ff_cnt), .hi(hi_cnt), .in_range(in_range), .fits(fits)
    );

    ab_frame_rx #(.CW(CW)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(state == ST_TRACK), .rx_s(rx_s),
        .fall(fall), .period(period_q), .done(f_done), .stop_ok(f_stop),
        .data(f_data)
    );

    assign lock_now  = (state == ST_SEARCH) && fall && fits && !pd_q;
    assign track_upd = f_done && f_stop && (f_data == SYNC_BYTE) &&
                       (rr_len <= CW'(LIMIT)) && (rr_len >= CW'(FF_BITS));

    // Acquisition and tracking sequence with bit-period updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SEARCH;
            period_q <= '0;
        end else begin
            case (state)
                ST_SEARCH: if (lock_now) begin
                    state    <= ST_ARMED;
                    period_q <= ff_cnt / CW'(FF_BITS);
                end
                ST_ARMED: if (fall) begin
                    if (fits) begin
                        state    <= ST_TRACK;
                        period_q <= ff_cnt / CW'(FF_BITS);
                    end else if (!in_range) begin
                        state <= ST_SEARCH;
                    end
                end
                ST_TRACK: if (track_upd) period_q <= rr_len / CW'(FF_BITS);
                default: state <= ST_SEARCH;
            endcase
        end
    end

    // Lock timeout: counts while searching, lock on the expiry edge wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_q <= '0;
            pd_q  <= 1'b0;
        end else if (state != ST_SEARCH || lock_now) begin
            tmo_q <= '0;
        end else if (!pd_q) begin
            if (tmo_q == TW'(TIMEOUT_CYCLES - 40'd1)) pd_q  <= 1'b1;
            else                                      tmo_q <= tmo_q + TW'(1);
        end
    end

    assign bit_period = period_q;
    assign locked     = (state != ST_SEARCH);
    assign rx_en      = (state == ST_TRACK);
    assign power_down = pd_q;

    // R10
    pd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> power_down);
    // R10
    pd_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |-> !locked);
    // R5
    en_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_en) |-> $past(locked));
    // R8
    period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRACK && !f_done) |=> $stable(bit_period));
    // R3
    period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_period <= CW'(LIMIT / FF_BITS));
endmodule

// File: tb/autobaud_detect_tb.sv
`timescale 1ns/1ps
module autobaud_detect_tb;
    localparam int          LIMIT = 4000;
    localparam int          CW    = 12;
    localparam int          T_TMO = 2000;
    localparam int          P     = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rx = 1'b1;
    logic [CW-1:0] bit_period, t_period;
    logic          locked, rx_en, power_down;
    logic          t_locked, t_rx_en, t_pd;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int lock_cyc = 0;

    always #2 clk = ~clk;

    autobaud_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx(rx), .bit_period(bit_period),
        .locked(locked), .rx_en(rx_en), .power_down(power_down)
    );

    autobaud_detect #(.LIMIT(LIMIT), .TIMEOUT_CYCLES(40'd2000)) u_tmo (
        .clk(clk), .rst_n(rst_n), .rx(rx), .bit_period(t_period),
        .locked(t_locked), .rx_en(t_rx_en), .power_down(t_pd)
    );

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    always @(negedge clk)
        if (rst_n && locked && lock_cyc == 0) lock_cyc = cyc;

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit cand_ok(input int ff, input int hi);
        int a, b, d;
        if (ff > LIMIT || hi > LIMIT) return 1'b0;
        a = 5 * ff;
        b = 7 * hi;
        d = (a > b) ? a - b : b - a;
        return d <= ff / 7;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rx = 1'b1;
        lock_cyc = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic idle(input int n);
        rx = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input int p);
        rx = 1'b0;
        repeat (p) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (p) @(negedge clk);
        end
        rx = 1'b1;
        repeat (p) @(negedge clk);
    endtask

    task automatic cand(input int ff, input int hi, input string tag);
        bit e;
        do_reset();
        idle(3);
        rx = 1'b0;
        repeat (ff - hi) @(negedge clk);
        rx = 1'b1;
        repeat (hi) @(negedge clk);
        rx = 1'b0;
        repeat (4) @(negedge clk);
        e = cand_ok(ff, hi);
        chk(tag, locked, e);
        if (e) chk(tag, bit_period, ff / 7);
        chk(tag, rx_en, 0);
        rx = 1'b1;
        idle(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R): actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n_meas, seed_v, ff, hi, off, span;
        seed_v = $urandom(32'h5EED);

        // R1 reset state
        do_reset();
        @(negedge clk);
        chk("R1 period", bit_period, 0);
        chk("R1 locked", locked, 0);
        chk("R1 rx_en", rx_en, 0);
        chk("R1 power_down", power_down, 0);

        // R2 tolerance edges, R3 limit edges, R4 load
        cand(70, 50, "R4 exact");
        cand(147, 102, "R2 tol edge in");
        cand(147, 101, "R2 tol edge out");
        cand(147, 108, "R2 tol edge hi in");
        cand(147, 109, "R2 tol edge hi out");
        cand(LIMIT, 2857, "R3 at limit");
        cand(LIMIT + 1, 2858, "R3 over limit");

        // R2 random candidates near the 7:5 shape
        for (int i = 0; i < 30; i++) begin
            ff   = 14 + int'($urandom_range(1300, 0));
            span = ff / 7 + 4;
            off  = int'($urandom_range(2 * span, 0)) - span;
            hi   = (5 * ff) / 7 + off;
            if (hi < 1) hi = 1;
            if (hi > ff - 1) hi = ff - 1;
            cand(ff, hi, "R2 random");
        end

        // R4/R5 doubled sync, R7/R8 tracking
        do_reset();
        idle(10);
        send_byte(8'h3E, P);
        chk("R4 locked after one", locked, 1);
        chk("R4 rx_en after one", rx_en, 0);
        chk("R4 period", bit_period, P);
        send_byte(8'h3E, P);
        idle(5);
        chk("R5 rx_en after two", rx_en, 1);
        chk("R5 period", bit_period, P);
        send_byte(8'h3C, 21);
        idle(30);
        chk("R8 other byte", bit_period, P);
        send_byte(8'h3E, 21);
        idle(30);
        chk("R7 drift up", bit_period, 21);
        send_byte(8'h3E, P);
        idle(30);
        chk("R7 drift back", bit_period, P);
        // candidate shaped 210/150 inside tracking must be ignored
        rx = 1'b0;
        repeat (60) @(negedge clk);
        rx = 1'b1;
        repeat (150) @(negedge clk);
        rx = 1'b0;
        repeat (400) @(negedge clk);
        idle(300);
        chk("R8 candidate ignored", bit_period, P);
        chk("R8 still enabled", rx_en, 1);

        // R6 long gap drops the half lock
        do_reset();
        idle(10);
        send_byte(8'h3E, P);
        idle(LIMIT + 200);
        rx = 1'b0;
        repeat (P) @(negedge clk);
        idle(10);
        chk("R6 dropped", locked, 0);
        send_byte(8'h3E, P);
        idle(5);
        chk("R6 relock", locked, 1);
        chk("R6 not enabled", rx_en, 0);

        // R11 measure the lock edge, then align it with the expiry edge
        do_reset();
        idle(10);
        send_byte(8'h3E, P);
        send_byte(8'h3E, P);
        idle(5);
        n_meas = lock_cyc;
        do_reset();
        idle(10 + T_TMO - n_meas);
        send_byte(8'h3E, P);
        send_byte(8'h3E, P);
        idle(20);
        chk("R11 lock wins", t_locked, 1);
        chk("R11 no power_down", t_pd, 0);
        chk("R11 enabled", t_rx_en, 1);

        // R10 one edge later: expiry first, sync ignored
        do_reset();
        idle(10 + T_TMO - n_meas + 1);
        send_byte(8'h3E, P);
        send_byte(8'h3E, P);
        idle(20);
        chk("R10 power_down", t_pd, 1);
        chk("R10 no lock", t_locked, 0);
        chk("R10 control locks", locked, 1);

        // R9 exact expiry edge
        do_reset();
        while (cyc < T_TMO - 1) @(negedge clk);
        chk("R9 before expiry", t_pd, 0);
        @(negedge clk);
        chk("R9 at expiry", t_pd, 1);
        repeat (50) @(negedge clk);
        chk("R10 sticky", t_pd, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule